// File: doc/BRIEF.md
# I/O-Port Bank-Select Enable Register

This block keeps the single enable flag of a banked memory card. The card has an 8-bit I/O address space. Software turns the card on or off by writing a byte to one configurable I/O port. One configured bit position of that byte decides the new state: a 1 turns the card on and a 0 turns it off. Several cards can share one port, each watching a different bit, so that one write can switch one bank off and another on together.

The flag takes a configured default at power-on clear. If no bit position is configured, port writes never touch it, and a card whose default is "on" then works as plain always-present memory. A separate active-low shadowing line from the bus can force the card off whenever shadowing is configured as honoured. The flag itself is left unchanged while the card is forced off.

Top module: `bank_enable_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flag loads `cfg_por_active`. With the shadowing line idle, `board_active` then equals that value.
- R2: A write changes the flag only when all 8 bits of `io_addr` equal `cfg_port`, with bit n of the address compared against bit n of the port value. A write to any other port, including one differing only in bit 7, leaves the flag unchanged.
- R3: A matching write (`io_wr` high at a rising edge) whose data bit at index `cfg_bit_sel` is 1 sets the flag on that edge.
- R4: A matching write whose selected data bit is 0 clears the flag on that edge.
- R5: Only the selected data bit matters. With index 0 selected, data 71h sets the flag and data 72h clears it. With index 7 selected, data 80h sets it and data 7Fh clears it.
- R6: With `io_wr` low, the flag holds its value over any number of cycles, whatever the address and data are.
- R7: With `cfg_bit_valid` low, matching writes never change the flag, whatever their data.
- R8: With `cfg_phantom_en` high and `phantom_n` low, `board_active` is 0. Releasing `phantom_n` restores the stored flag.
- R9: With `cfg_phantom_en` low, `phantom_n` has no effect on `board_active`.
- R10: `board_active` follows changes of `phantom_n` and `cfg_phantom_en` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on clear, active high |
| io_wr | input | 1 | I/O output-write strobe, one cycle per write |
| io_addr | input | 8 | I/O port address of the write |
| io_wdata | input | 8 | Data byte of the write |
| cfg_port | input | 8 | Configured port number |
| cfg_bit_sel | input | 3 | Configured index of the controlling data bit |
| cfg_bit_valid | input | 1 | High when a controlling data bit is configured |
| cfg_por_active | input | 1 | Flag value loaded at power-on clear |
| cfg_phantom_en | input | 1 | High to honour the shadowing line |
| phantom_n | input | 1 | Bus shadowing line, active low |
| board_active | output | 1 | Effective card enable |

## Verification
A vector table walks writes that match the port with the selected bit set, match with it cleared, and match with other bits set in a conflicting pattern. This tells the selected bit apart from its neighbours and from the byte as a whole. The table also has near-miss addresses that differ in the top or bottom bit, which shows whether every address bit takes part in the compare. It repeats this at the extreme ports 00h and FFh with bit indices 0, 3 and 7, and it runs writes with no bit configured. Directed steps cover both power-on defaults, long idle stretches with matching address and data but no strobe, and the shadowing line toggled between clock edges with shadowing both honoured and ignored. These steps separate the combinational override from the stored flag.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

    parameter int BSEL_ADDR_W = 8;
    parameter int BSEL_DATA_W = 8;
    parameter int BSEL_SEL_W  = $clog2(BSEL_DATA_W);

    // One I/O output cycle as seen by the block.
    typedef struct packed {
        logic                   strobe;
        logic [BSEL_ADDR_W-1:0] addr;
        logic [BSEL_DATA_W-1:0] data;
    } io_cycle_t;

    // Configuration that decides when a write is acted on.
    typedef struct packed {
        logic [BSEL_ADDR_W-1:0] port;
        logic [BSEL_SEL_W-1:0]  bit_sel;
        logic                   bit_valid;
    } sel_cfg_t;

    // Next flag value computed from the current flag and an effective update.
    function automatic logic next_flag(input logic cur, input logic upd, input logic val);
        return upd ? val : cur;
    endfunction

endpackage

// File: rtl/bsel_port_match.sv
module bsel_port_match #(
    parameter int ADDR_W = bank_sel_pkg::BSEL_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] port,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_eq;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
        assign bit_eq[i] = ~(addr[i] ^ port[i]);
    end

    assign hit = &bit_eq;
endmodule

// File: rtl/bsel_state_reg.sv
module bsel_state_reg (
    input  logic clk,
    input  logic rst,
    input  logic por_val,
    input  logic upd,
    input  logic upd_val,
    output logic flag_q
);
    import bank_sel_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= por_val;
        else     flag_q <= next_flag(flag_q, upd, upd_val);
    end
endmodule

// File: rtl/bsel_phantom_gate.sv
module bsel_phantom_gate (
    input  logic flag_q,
    input  logic phantom_en,
    input  logic phantom_n,
    output logic active
);
    logic shadowed;

    always_comb begin
        shadowed = phantom_en & ~phantom_n;
        active   = flag_q & ~shadowed;
    end
endmodule

// File: rtl/bank_enable_reg.sv
module bank_enable_reg
    import bank_sel_pkg::*;
#(
    parameter int ADDR_W = BSEL_ADDR_W,
    parameter int DATA_W = BSEL_DATA_W,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [ADDR_W-1:0] cfg_port,
    input  logic [SEL_W-1:0]  cfg_bit_sel,
    input  logic              cfg_bit_valid,
    input  logic              cfg_por_active,
    input  logic              cfg_phantom_en,
    input  logic              phantom_n,
    output logic              board_active
);
    logic port_hit;
    logic sel_bit;
    logic upd;
    logic flag_q;

    bsel_port_match #(.ADDR_W(ADDR_W)) u_match (
        .addr (io_addr),
        .port (cfg_port),
        .hit  (port_hit)
    );

    assign sel_bit = io_wdata[cfg_bit_sel];
    assign upd     = io_wr & port_hit & cfg_bit_valid;

    bsel_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .por_val (cfg_por_active),
        .upd     (upd),
        .upd_val (sel_bit),
        .flag_q  (flag_q)
    );

    bsel_phantom_gate u_gate (
        .flag_q     (flag_q),
        .phantom_en (cfg_phantom_en),
        .phantom_n  (phantom_n),
        .active     (board_active)
    );

    // R3 / R4: a matching, enabled write stores the chosen data bit
    a_r3_write_loads_bit: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == cfg_port && cfg_bit_valid) |=> flag_q == $past(io_wdata[cfg_bit_sel]));

    // R2: writes to any other port leave the flag alone
    a_r2_other_port_ignored: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr != cfg_port) |=> $stable(flag_q));

    // R6: without a strobe the flag holds
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> $stable(flag_q));

    // R7: with no bit configured writes have no effect
    a_r7_no_bit_no_change: assert property (@(posedge clk) disable iff (rst)
        !cfg_bit_valid |=> $stable(flag_q));

    // R8: honoured shadowing forces the card off
    a_r8_phantom_forces_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_phantom_en && !phantom_n) |-> !board_active);

    // R9: ignored shadowing leaves the stored flag visible
    a_r9_phantom_ignored: assert property (@(posedge clk) disable iff (rst)
        !cfg_phantom_en |-> board_active == flag_q);
endmodule

// File: tb/bank_enable_reg_tb.sv
module bank_enable_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] cfg_port = 8'h40;
    logic [2:0] cfg_bit_sel = '0;
    logic       cfg_bit_valid = 1'b1;
    logic       cfg_por_active = 1'b0;
    logic       cfg_phantom_en = 1'b0;
    logic       phantom_n = 1'b1;
    logic       board_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bank_enable_reg u_dut (
        .clk            (clk),
        .rst            (rst),
        .io_wr          (io_wr),
        .io_addr        (io_addr),
        .io_wdata       (io_wdata),
        .cfg_port       (cfg_port),
        .cfg_bit_sel    (cfg_bit_sel),
        .cfg_bit_valid  (cfg_bit_valid),
        .cfg_por_active (cfg_por_active),
        .cfg_phantom_en (cfg_phantom_en),
        .phantom_n      (phantom_n),
        .board_active   (board_active)
    );

    // {port, bit_sel, valid, addr, data, expected flag after the write}
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {8'h40, 3'd0, 1'b1, 8'h40, 8'h71, 1'b1},  // R3 R5
        {8'h40, 3'd0, 1'b1, 8'h40, 8'h72, 1'b0},  // R4 R5
        {8'h40, 3'd0, 1'b1, 8'h41, 8'hFF, 1'b0},  // R2 low bit differs
        {8'h40, 3'd0, 1'b1, 8'h40, 8'h01, 1'b1},  // R3
        {8'h40, 3'd0, 1'b1, 8'hC0, 8'h00, 1'b1},  // R2 top bit differs
        {8'hFF, 3'd7, 1'b1, 8'hFF, 8'h80, 1'b1},  // R5 bit 7 set
        {8'hFF, 3'd7, 1'b1, 8'hFF, 8'h7F, 1'b0},  // R5 bit 7 clear
        {8'hFF, 3'd7, 1'b1, 8'h7F, 8'h80, 1'b0},  // R2
        {8'h00, 3'd3, 1'b1, 8'h00, 8'h08, 1'b1},  // R3
        {8'h00, 3'd3, 1'b0, 8'h00, 8'h00, 1'b1},  // R7
        {8'h00, 3'd3, 1'b1, 8'h00, 8'hF7, 1'b0},  // R4
        {8'h00, 3'd3, 1'b0, 8'h00, 8'hFF, 1'b0}   // R7
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: board_active=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; the write is taken at the next posedge.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_reset(input logic por);
        cfg_por_active = por;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: both power-on defaults
        do_reset(1'b1);
        chk("R1 por active", board_active, 1'b1);
        do_reset(1'b0);
        chk("R1 por inactive", board_active, 1'b0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            cfg_port      = VEC[i][28:21];
            cfg_bit_sel   = VEC[i][20:18];
            cfg_bit_valid = VEC[i][17];
            do_write(VEC[i][16:9], VEC[i][8:1]);
            chk($sformatf("R2-5/R7 vector %0d", i), board_active, VEC[i][0]);
        end

        // R6: no strobe, matching address and setting data, long idle
        cfg_port = 8'h55; cfg_bit_sel = 3'd2; cfg_bit_valid = 1'b1;
        io_addr = 8'h55; io_wdata = 8'hFF;
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk("R6 hold while idle", board_active, 1'b0);
        do_write(8'h55, 8'h04);
        for (int k = 0; k < 20; k++) begin
            io_wdata = 8'(k);
            @(negedge clk);
        end
        chk("R6 hold set flag", board_active, 1'b1);

        // R8 / R10: shadowing honoured, observed without a clock edge
        cfg_phantom_en = 1'b1;
        #1 phantom_n = 1'b0;
        #1 chk("R8 R10 forced off", board_active, 1'b0);
        @(negedge clk);
        phantom_n = 1'b1;
        #1 chk("R8 R10 released restores flag", board_active, 1'b1);

        // R9: shadowing ignored
        @(negedge clk);
        cfg_phantom_en = 1'b0;
        phantom_n = 1'b0;
        #1 chk("R9 line ignored", board_active, 1'b1);
        @(negedge clk);
        cfg_phantom_en = 1'b1;
        #1 chk("R10 enable takes effect at once", board_active, 1'b0);
        @(negedge clk);
        cfg_phantom_en = 1'b0; phantom_n = 1'b1;

        // R1: power-on clear overrides a set flag
        do_reset(1'b0);
        chk("R1 reset clears set flag", board_active, 1'b0);

        // R7 with default on: plain always-on memory
        cfg_bit_valid = 1'b0;
        do_reset(1'b1);
        do_write(8'h55, 8'h00);
        chk("R7 always-on ignores write", board_active, 1'b1);

        @(negedge clk);
        finish_run();
    end
endmodule